// File: doc/BRIEF.md
# Translation Cache with Selective Flush

This block is a small, fully associative cache of address translations. Each slot holds a valid flag, a 3-bit function code and a logical page number. A fill port writes new translations into slots in round-robin order. A combinational lookup port reports whether a valid slot holds exactly the requested function code and page.

The flush port takes a 16-bit command word together with an effective address, the low three bits of each of the eight data registers, and the current source and destination function-code registers. The command word says which slots to drop:
- every slot,
- slots whose function code matches under a per-bit compare mask, or
- slots that match on both the masked function code and the page.

The function code used for the compare comes from one of four places, also chosen by the command word. All slots that match are cleared in a single cycle. A malformed command raises a one-cycle illegal flag and clears nothing. The block has no status register, so a flush changes no other output.

Top module: `xlat_flush_cache`

## Requirements
- R1: After reset every slot is invalid, `look_hit` is 0 for every input, and `flush_done` and `flush_illegal` are 0.
- R2: A fill writes the function code and page (address bits above `OFFSET_W`, default 12) into one slot. Once the fill has completed, a lookup with the same function code and any address in that page reports a hit.
- R3: Fills go to the slots in round-robin order over the `ENTRIES` slots (default 22), starting from slot 0 after reset. After 22 fills, the 23rd fill replaces the first entry.
- R4: A legal flush with mode field `cmd[12:10]` = 001 invalidates every slot.
- R5: A legal flush with mode 100 invalidates each valid slot whose function code equals the resolved code in every bit position where mask `cmd[7:5]` is 1. Positions where the mask is 0 always match.
- R6: A legal flush with mode 110 invalidates only slots that meet the R5 rule and whose page equals the page of `flush_addr`. The offset bits of `flush_addr` are ignored.
- R7: Selector `cmd[4:0]` = 10xxx uses the immediate xxx as the function code. Selector 01ddd uses bits 2:0 of data register ddd, which sit at `flush_dregs[3*ddd+2 : 3*ddd]`.
- R8: Selector 00000 uses `flush_sfc` and selector 00001 uses `flush_dfc`.
- R9: A command is illegal if any of the following holds: `cmd[15:13]` is not 001, `cmd[9:8]` is not 00, the mode is not one of 001, 100 or 110, or the selector is not one of the four forms. An illegal command raises `flush_illegal` for exactly the following cycle, does not raise `flush_done`, and leaves every slot unchanged.
- R10: A legal flush raises `flush_done` for exactly the cycle after the one in which it was accepted. `flush_done` and `flush_illegal` are never high together.
- R11: If a fill and a flush are accepted in the same cycle, the flush is applied first and the fill is written afterwards, so the newly filled slot is valid afterwards.
- R12: A lookup hits only on an exact match of all three function-code bits. The flush mask has no effect on lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Write a new translation this cycle |
| fill_fc | input | 3 | Function code of the new translation |
| fill_addr | input | ADDR_W | Address whose page is stored |
| look_fc | input | 3 | Lookup function code |
| look_addr | input | ADDR_W | Lookup address |
| look_hit | output | 1 | Combinational hit for the lookup |
| flush_valid | input | 1 | Flush command present this cycle |
| flush_cmd | input | 16 | Flush command word |
| flush_addr | input | ADDR_W | Address used by mode 110 |
| flush_dregs | input | 24 | Bits 2:0 of data registers 0 to 7, register n at bits 3n+2:3n |
| flush_sfc | input | 3 | Source function-code register |
| flush_dfc | input | 3 | Destination function-code register |
| flush_done | output | 1 | Pulse one cycle after a legal flush |
| flush_illegal | output | 1 | Pulse one cycle after a malformed flush |

## Verification
The assertions check the following on every cycle:
- the done and illegal pulses never overlap, and a legal flush is always followed by done;
- an illegal command leaves the valid flags untouched;
- a flush-all empties the cache;
- a filled slot is valid with the written code on the next cycle, even when a flush arrives in the same cycle;
- the replacement pointer stays in range.

Some behaviours can only be shown by the bench's scenarios, because they depend on which entries survive:
- the masked function-code compare, swept over every mask and code value;
- page matching;
- the choice of function-code source;
- round-robin wrap-around.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    localparam int FC_W     = 3;
    localparam int NUM_DREG = 8;
    localparam int CMD_W    = 16;

    localparam logic [2:0] MODE_ALL     = 3'b001;
    localparam logic [2:0] MODE_FC      = 3'b100;
    localparam logic [2:0] MODE_FC_PAGE = 3'b110;

    typedef struct packed {
        logic            flush_all;
        logic            use_page;
        logic [FC_W-1:0] mask;
        logic [FC_W-1:0] fc;
    } flush_req_t;
endpackage

// File: rtl/xfc_cmd_decode.sv
module xfc_cmd_decode
    import xfc_pkg::*;
(
    input  logic [CMD_W-1:0]               cmd,
    input  logic [NUM_DREG-1:0][FC_W-1:0]  dregs,
    input  logic [FC_W-1:0]                sfc,
    input  logic [FC_W-1:0]                dfc,
    output logic                           legal,
    output flush_req_t                     req
);
    logic [2:0] mode;
    logic [4:0] sel;
    logic       hdr_ok;
    logic       mode_ok;
    logic       sel_ok;
    logic [FC_W-1:0] fc_sel;

    always_comb begin
        mode    = cmd[12:10];
        sel     = cmd[4:0];
        hdr_ok  = (cmd[15:13] == 3'b001) && (cmd[9:8] == 2'b00);
        mode_ok = (mode == MODE_ALL) || (mode == MODE_FC) || (mode == MODE_FC_PAGE);
        sel_ok  = 1'b1;
        fc_sel  = '0;
        if (sel[4:3] == 2'b10) begin
            fc_sel = sel[2:0];
        end else if (sel[4:3] == 2'b01) begin
            fc_sel = dregs[sel[2:0]];
        end else if (sel == 5'b00000) begin
            fc_sel = sfc;
        end else if (sel == 5'b00001) begin
            fc_sel = dfc;
        end else begin
            sel_ok = 1'b0;
        end
        legal         = hdr_ok && mode_ok && sel_ok;
        req.flush_all = (mode == MODE_ALL);
        req.use_page  = (mode == MODE_FC_PAGE);
        req.mask      = cmd[7:5];
        req.fc        = fc_sel;
    end
endmodule

// File: rtl/xfc_entry_array.sv
module xfc_entry_array
    import xfc_pkg::*;
#(
    parameter int ENTRIES = 22,
    parameter int PAGE_W  = 20
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush_en,
    input  flush_req_t                       req,
    input  logic [PAGE_W-1:0]                flush_page,
    input  logic                             fill_en,
    input  logic [FC_W-1:0]                  fill_fc,
    input  logic [PAGE_W-1:0]                fill_page,
    output logic [ENTRIES-1:0]               valid_o,
    output logic [ENTRIES-1:0][FC_W-1:0]     fc_o,
    output logic [ENTRIES-1:0][PAGE_W-1:0]   page_o
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][FC_W-1:0]   fc;
        logic [ENTRIES-1:0][PAGE_W-1:0] page;
        logic [PTR_W-1:0]               ptr;
    } ent_t;

    ent_t ent_d, ent_q;
    logic [ENTRIES-1:0] kill;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        logic fc_ok;
        logic pg_ok;
        assign fc_ok   = (((ent_q.fc[g] ^ req.fc) & req.mask) == '0);
        assign pg_ok   = !req.use_page || (ent_q.page[g] == flush_page);
        assign kill[g] = flush_en && (req.flush_all || (fc_ok && pg_ok));
    end

    always_comb begin
        ent_d       = ent_q;
        ent_d.valid = ent_q.valid & ~kill;
        if (fill_en) begin
            ent_d.valid[ent_q.ptr] = 1'b1;
            ent_d.fc[ent_q.ptr]    = fill_fc;
            ent_d.page[ent_q.ptr]  = fill_page;
            ent_d.ptr = (ent_q.ptr == LAST) ? '0 : ent_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign valid_o = ent_q.valid;
    assign fc_o    = ent_q.fc;
    assign page_o  = ent_q.page;

    a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ent_q.ptr <= LAST);

    a_r4_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && req.flush_all && !fill_en) |=> (valid_o == '0));

    a_r11_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_o[$past(ent_q.ptr)] && (fc_o[$past(ent_q.ptr)] == $past(fill_fc))));
endmodule

// File: rtl/xfc_lookup.sv
module xfc_lookup
    import xfc_pkg::*;
#(
    parameter int ENTRIES = 22,
    parameter int PAGE_W  = 20
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ENTRIES-1:0]               valid,
    input  logic [ENTRIES-1:0][FC_W-1:0]     fc,
    input  logic [ENTRIES-1:0][PAGE_W-1:0]   page,
    input  logic [FC_W-1:0]                  look_fc,
    input  logic [PAGE_W-1:0]                look_page,
    output logic                             hit
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (fc[g] == look_fc) && (page[g] == look_page);
    end

    assign hit = |match;

    a_r1_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (valid == '0) |-> !hit);
endmodule

// File: rtl/xlat_flush_cache.sv
module xlat_flush_cache
    import xfc_pkg::*;
#(
    parameter int ENTRIES  = 22,
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fill_valid,
    input  logic [2:0]                fill_fc,
    input  logic [ADDR_W-1:0]         fill_addr,
    input  logic [2:0]                look_fc,
    input  logic [ADDR_W-1:0]         look_addr,
    output logic                      look_hit,
    input  logic                      flush_valid,
    input  logic [15:0]               flush_cmd,
    input  logic [ADDR_W-1:0]         flush_addr,
    input  logic [23:0]               flush_dregs,
    input  logic [2:0]                flush_sfc,
    input  logic [2:0]                flush_dfc,
    output logic                      flush_done,
    output logic                      flush_illegal
);
    localparam int PAGE_W = ADDR_W - OFFSET_W;

    typedef struct packed {
        logic done;
        logic illegal;
    } st_t;

    st_t st_d, st_q;

    logic                            legal;
    flush_req_t                      req;
    logic [ENTRIES-1:0]              valid_v;
    logic [ENTRIES-1:0][FC_W-1:0]    fc_v;
    logic [ENTRIES-1:0][PAGE_W-1:0]  page_v;
    logic                            unused_offset_bits;

    assign unused_offset_bits = ^{fill_addr[OFFSET_W-1:0], look_addr[OFFSET_W-1:0],
                                  flush_addr[OFFSET_W-1:0]};

    xfc_cmd_decode u_dec (
        .cmd   (flush_cmd),
        .dregs (flush_dregs),
        .sfc   (flush_sfc),
        .dfc   (flush_dfc),
        .legal (legal),
        .req   (req)
    );

    xfc_entry_array #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_en   (flush_valid && legal),
        .req        (req),
        .flush_page (flush_addr[ADDR_W-1:OFFSET_W]),
        .fill_en    (fill_valid),
        .fill_fc    (fill_fc),
        .fill_page  (fill_addr[ADDR_W-1:OFFSET_W]),
        .valid_o    (valid_v),
        .fc_o       (fc_v),
        .page_o     (page_v)
    );

    xfc_lookup #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_look (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (valid_v),
        .fc        (fc_v),
        .page      (page_v),
        .look_fc   (look_fc),
        .look_page (look_addr[ADDR_W-1:OFFSET_W]),
        .hit       (look_hit)
    );

    always_comb begin
        st_d.done    = flush_valid && legal;
        st_d.illegal = flush_valid && !legal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush_done    = st_q.done;
    assign flush_illegal = st_q.illegal;

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_done && flush_illegal));

    a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && legal) |=> flush_done);

    a_r9_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !legal && !fill_valid) |=> ($stable(valid_v) && flush_illegal && !flush_done));
endmodule

// File: tb/xlat_flush_cache_test.sv
`timescale 1ns/1ps
module xlat_flush_cache_test;
    localparam int N = 22;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        fill_valid = 0;
    logic [2:0]  fill_fc = 0;
    logic [31:0] fill_addr = 0;
    logic [2:0]  look_fc = 0;
    logic [31:0] look_addr = 0;
    logic        look_hit;
    logic        flush_valid = 0;
    logic [15:0] flush_cmd = 0;
    logic [31:0] flush_addr = 0;
    logic [23:0] flush_dregs = 0;
    logic [2:0]  flush_sfc = 0;
    logic [2:0]  flush_dfc = 0;
    logic        flush_done;
    logic        flush_illegal;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit m_v [N];
    int m_fc[N];
    int m_pg[N];
    int m_ptr;

    always #2.5 clk = ~clk;

    xlat_flush_cache uut (.*);

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(logic [2:0] mode, logic [2:0] mask, logic [4:0] sel);
        return {3'b001, mode, 2'b00, mask, sel};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        foreach (m_v[i]) begin m_v[i] = 0; m_fc[i] = 0; m_pg[i] = 0; end
        m_ptr = 0;
    endtask

    task automatic model_fill(int fc, int pg);
        m_v[m_ptr] = 1; m_fc[m_ptr] = fc; m_pg[m_ptr] = pg;
        m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
    endtask

    task automatic fill(int fc, int pg);
        @(negedge clk);
        fill_valid = 1; fill_fc = 3'(fc); fill_addr = {20'(pg), 12'h5A7};
        @(negedge clk);
        fill_valid = 0;
        model_fill(fc, pg);
    endtask

    task automatic fill_all();
        for (int i = 0; i < N; i++) fill(i % 8, 32'h100 + i);
    endtask

    function automatic bit model_hit(int fc, int pg);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_fc[i] == fc && m_pg[i] == pg) return 1;
        return 0;
    endfunction

    task automatic look(int fc, logic [31:0] addr, output bit h);
        look_fc = 3'(fc); look_addr = addr;
        #1;
        h = look_hit;
    endtask

    task automatic check_all(string req);
        bit h;
        for (int i = 0; i < N; i++) begin
            look(m_fc[i], {20'(m_pg[i]), 12'h0F3}, h);
            chk(h == model_hit(m_fc[i], m_pg[i]), req, h, model_hit(m_fc[i], m_pg[i]));
        end
    endtask

    task automatic resolve(logic [15:0] c, output bit ok, output int fc);
        logic [4:0] s;
        logic [2:0] md;
        s = c[4:0]; md = c[12:10];
        ok = (c[15:13] == 3'b001) && (c[9:8] == 2'b00) &&
             (md == 3'b001 || md == 3'b100 || md == 3'b110);
        fc = 0;
        if (s[4:3] == 2'b10) fc = int'(s[2:0]);
        else if (s[4:3] == 2'b01) fc = int'(flush_dregs[3*s[2:0] +: 3]);
        else if (s == 5'b00000) fc = int'(flush_sfc);
        else if (s == 5'b00001) fc = int'(flush_dfc);
        else ok = 0;
    endtask

    task automatic model_flush(logic [15:0] c, int fc, int pg);
        int mask;
        mask = int'(c[7:5]);
        for (int i = 0; i < N; i++) begin
            if (c[12:10] == 3'b001) m_v[i] = 0;
            else if ((((m_fc[i] ^ fc) & mask) == 0) &&
                     (c[12:10] != 3'b110 || m_pg[i] == pg)) m_v[i] = 0;
        end
    endtask

    task automatic flush(logic [15:0] c, logic [31:0] addr, string req);
        bit ok;
        int fc;
        @(negedge clk);
        flush_valid = 1; flush_cmd = c; flush_addr = addr;
        resolve(c, ok, fc);
        @(negedge clk);
        flush_valid = 0;
        chk(flush_done == ok, ok ? "R10" : "R9", flush_done, ok);
        chk(flush_illegal == !ok, "R9", flush_illegal, !ok);
        if (ok) model_flush(c, fc, int'(addr[31:12]));
        check_all(req);
    endtask

    initial begin
        bit h;
        do_reset();
        // R1: reset state
        chk(flush_done == 0, "R1", flush_done, 0);
        chk(flush_illegal == 0, "R1", flush_illegal, 0);
        for (int i = 0; i < 8; i++) begin
            look(i, 32'h0010_0000 + i * 4096, h);
            chk(h == 0, "R1", h, 0);
        end

        // R2 and R12: fill and exact lookup
        fill_all();
        check_all("R2");
        look(1, 32'h0010_1FFF, h); chk(h == 1, "R2", h, 1);
        look(1, 32'h0010_1000, h); chk(h == 1, "R2", h, 1);
        look(5, 32'h0010_1000, h); chk(h == 0, "R12", h, 0);
        look(3, 32'h0010_1000, h); chk(h == 0, "R12", h, 0);

        // R5: every mask against every immediate code
        for (int mk_i = 0; mk_i < 8; mk_i++)
            for (int f = 0; f < 8; f++) begin
                fill_all();
                flush(mk(3'b100, 3'(mk_i), {2'b10, 3'(f)}), 32'h0, "R5");
            end

        // R6: masked code and page
        for (int mk_i = 0; mk_i < 8; mk_i += 3)
            for (int t = 0; t < N; t += 4) begin
                fill_all();
                flush(mk(3'b110, 3'(mk_i), {2'b10, 3'(t % 8)}), {20'(32'h100 + t), 12'hFFF}, "R6");
                flush(mk(3'b110, 3'b111, {2'b10, 3'((t + 1) % 8)}), {20'(32'h100 + t + 1), 12'h001}, "R6");
            end

        // R7: data register sources
        for (int d = 0; d < 8; d++) begin
            for (int r = 0; r < 8; r++) flush_dregs[3*r +: 3] = 3'((r + 5) % 8);
            flush_dregs[3*d +: 3] = 3'((d * 3 + 1) % 8);
            fill_all();
            flush(mk(3'b100, 3'b111, {2'b01, 3'(d)}), 32'h0, "R7");
        end

        // R8: source and destination code registers
        flush_sfc = 3'd6; flush_dfc = 3'd2;
        fill_all();
        flush(mk(3'b100, 3'b111, 5'b00000), 32'h0, "R8");
        flush(mk(3'b100, 3'b111, 5'b00001), 32'h0, "R8");
        flush_sfc = 3'd3;
        fill_all();
        flush(mk(3'b110, 3'b111, 5'b00000), 32'h0010_3000, "R8");

        // R4: flush all
        fill_all();
        flush(mk(3'b001, 3'b000, 5'b10000), 32'h0, "R4");

        // R9: malformed commands
        fill_all();
        flush(16'h0000 | mk(3'b100, 3'b111, 5'b10001) & 16'h1FFF, 32'h0, "R9");
        flush(mk(3'b100, 3'b111, 5'b10001) | 16'h4000, 32'h0, "R9");
        flush(mk(3'b100, 3'b111, 5'b10001) | 16'h0100, 32'h0, "R9");
        flush(mk(3'b001, 3'b000, 5'b10000) | 16'h0200, 32'h0, "R9");
        for (int md = 0; md < 8; md++)
            if (md != 1 && md != 4 && md != 6)
                flush(mk(3'(md), 3'b111, 5'b10001), 32'h0, "R9");
        flush(mk(3'b100, 3'b111, 5'b00010), 32'h0, "R9");
        flush(mk(3'b100, 3'b111, 5'b11001), 32'h0, "R9");
        flush(mk(3'b001, 3'b111, 5'b00111), 32'h0, "R9");

        // R3: wrap-around replacement
        do_reset();
        fill_all();
        fill(7, 32'h500);
        check_all("R3");
        look(0, 32'h0010_0000, h); chk(h == 0, "R3", h, 0);
        look(7, 32'h0050_0000, h); chk(h == 1, "R3", h, 1);
        look(1, 32'h0010_1000, h); chk(h == 1, "R3", h, 1);

        // R11: fill together with flush-all
        fill_all();
        @(negedge clk);
        fill_valid = 1; fill_fc = 3'd4; fill_addr = 32'h0077_7123;
        flush_valid = 1; flush_cmd = mk(3'b001, 3'b000, 5'b10000);
        @(negedge clk);
        fill_valid = 0; flush_valid = 0;
        chk(flush_done == 1, "R10", flush_done, 1);
        model_flush(mk(3'b001, 3'b000, 5'b10000), 0, 0);
        model_fill(4, 32'h777);
        look(4, 32'h0077_7000, h); chk(h == 1, "R11", h, 1);
        check_all("R11");
        @(negedge clk);
        chk(flush_done == 0, "R10", flush_done, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule